// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Byte Path

This block is the transmit half of a byte-wide clocked serial port. Software writes a byte into a holding register through a simple register port. While the shifter is idle, a pending byte moves into the shift register one clock later. The bits then leave on the serial data output, one bit for each pulse of the serial clock enable. A second byte written while a frame is still shifting waits in the holding register. It is taken over on the same clock edge that retires the last bit of the current frame, so consecutive frames leave with no idle bit between them.

A mode input picks the bit order. In LSB-first mode the byte is stored bit-mirrored, so software reading the holding register back sees the written value with its bits reversed. Status outputs report an empty holding register, an active shifter, the end of transmission, and a sticky overrun.

Top module: `tx_holdshift`

## Requirements
- R1: After reset the holding register reads 0xFF, thr_empty is 1, and busy, tx_end and overrun are 0. sdo is 1.
- R2: A cycle with wr_en high stores wr_data in the holding register, and thr_empty is 0 from the next cycle on.
- R3: When the holding register is full and the shifter is idle, the byte is loaded into the shifter on the next clock edge. busy becomes 1 and thr_empty becomes 1.
- R4: When lsb_first is 1 during a write, rd_data afterwards returns the written byte with bit i moved to bit 7-i. When lsb_first is 0, rd_data returns the byte unchanged.
- R5: While busy, sdo presents the current bit and advances one bit per cycle with sclk_en high. It holds its value in cycles with sclk_en low. For a byte written with lsb_first 0, bit 7 goes out first and bit 0 last. For a byte written with lsb_first 1, bit 0 goes out first and bit 7 last.
- R6: If the holding register is full when the eighth sclk_en pulse of a frame arrives, the next byte is loaded on that same edge. busy stays 1, and sdo shows the first bit of the new byte in the following cycle.
- R7: tx_end becomes 1 on the edge that retires the eighth bit while the holding register is empty. It stays 1 until the next write, which clears it.
- R8: A write while the holding register is full and not being loaded replaces the pending byte and sets overrun. overrun stays 1 until a cycle with ovr_clr high. A new overrun in that same cycle wins over the clear.
- R9: sdo is 1 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| lsb_first | input | 1 | Bit order mode: 1 sends the LSB first |
| ovr_clr | input | 1 | Clears the overrun flag |
| sclk_en | input | 1 | Serial clock enable: one bit advances per pulse |
| rd_data | output | 8 | Holding register read value |
| sdo | output | 1 | Serial data output |
| thr_empty | output | 1 | Holding register empty |
| busy | output | 1 | Shifter is transmitting |
| tx_end | output | 1 | Transmission finished with nothing pending |
| overrun | output | 1 | Sticky pending-byte overwrite flag |

## Verification
The assertions assume that lsb_first does not change between a write and the end of that byte's frame. The shifter uses the order fixed at write time, and only a stable mode gives a meaningful readback. They also assume that sclk_en comes as single-cycle pulses driven by the serial clock divider. The bench changes lsb_first only while the shifter is idle and no byte is pending. It raises sclk_en for single cycles and sometimes leaves idle cycles between pulses. Every byte value is swept in both orders within these limits.

// File: rtl/tx_holdshift.sv
module tx_holdshift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          lsb_first,
  input  logic          ovr_clr,
  input  logic          sclk_en,
  output logic [DW-1:0] rd_data,
  output logic          sdo,
  output logic          thr_empty,
  output logic          busy,
  output logic          tx_end,
  output logic          overrun
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] hold, shreg, wr_mirr;
  logic [CW-1:0] cnt;
  logic          hold_full, active, end_q, ovr_q;

  for (genvar i = 0; i < DW; i++) begin : g_mirr
    assign wr_mirr[i] = wr_data[DW-1-i];
  end

  wire finish = active && sclk_en && (cnt == LAST);
  wire load   = hold_full && (!active || finish);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '1;
      hold_full <= 1'b0;
      shreg     <= '1;
      cnt       <= '0;
      active    <= 1'b0;
      end_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (wr_en) hold <= lsb_first ? wr_mirr : wr_data;

      if (wr_en)     hold_full <= 1'b1;
      else if (load) hold_full <= 1'b0;

      if (load) begin
        shreg  <= hold;
        cnt    <= '0;
        active <= 1'b1;
      end else if (active && sclk_en) begin
        if (cnt == LAST) begin
          active <= 1'b0;
        end else begin
          shreg <= {shreg[DW-2:0], 1'b1};
          cnt   <= cnt + 1'b1;
        end
      end

      if (wr_en)                      end_q <= 1'b0;
      else if (finish && !hold_full)  end_q <= 1'b1;

      if (wr_en && hold_full && !load) ovr_q <= 1'b1;
      else if (ovr_clr)                ovr_q <= 1'b0;
    end
  end

  assign rd_data   = hold;
  assign sdo       = active ? shreg[DW-1] : 1'b1;
  assign thr_empty = !hold_full;
  assign busy      = active;
  assign tx_end    = end_q;
  assign overrun   = ovr_q;
endmodule

module tx_holdshift_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          lsb_first,
  input logic          ovr_clr,
  input logic          sclk_en,
  input logic [DW-1:0] rd_data,
  input logic          sdo,
  input logic          thr_empty,
  input logic          busy,
  input logic          tx_end,
  input logic          overrun
);
  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sdo);
  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !thr_empty);
  assert_idle_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_empty && !busy) |=> busy);
  assert_hold_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sclk_en) |=> $stable(sdo));
  assert_end_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> (thr_empty && !busy));
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
  assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !thr_empty && busy && !sclk_en) |=> overrun);
endmodule

bind tx_holdshift tx_holdshift_chk #(.DW(DW)) u_chk (.*);

// File: tb/tx_holdshift_bench.sv
module tx_holdshift_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       lsb_first = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       sclk_en = 1'b0;
  logic [7:0] rd_data;
  logic       sdo, thr_empty, busy, tx_end, overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tx_holdshift u_tx_holdshift (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .lsb_first(lsb_first), .ovr_clr(ovr_clr), .sclk_en(sclk_en),
    .rd_data(rd_data), .sdo(sdo), .thr_empty(thr_empty), .busy(busy),
    .tx_end(tx_end), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mirror(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic bit_at(input logic [7:0] b, input logic lsb, input int i);
    return lsb ? b[i] : b[7-i];
  endfunction

  task automatic write_byte(input logic [7:0] b, input logic lsb);
    lsb_first = lsb; wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse;
    sclk_en = 1'b1;
    @(negedge clk);
    sclk_en = 1'b0;
  endtask

  task automatic shift_frame(input logic [7:0] b, input logic lsb, input bit gaps);
    for (int i = 0; i < 8; i++) begin
      chk("R5 bit", sdo, bit_at(b, lsb, i));
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        chk("R5 hold", sdo, bit_at(b, lsb, i));
      end
      pulse();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rd", rd_data, 8'hFF);
    chk("R1 empty", thr_empty, 1);
    chk("R1 busy", busy, 0);
    chk("R1 end", tx_end, 0);
    chk("R1 ovr", overrun, 0);
    chk("R1 sdo", sdo, 1);

    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b;
        b = 8'(v);
        write_byte(b, m[0]);
        chk("R2 full", thr_empty, 0);
        chk("R7 cleared", tx_end, 0);
        chk("R4 rd", rd_data, m[0] ? mirror(b) : b);
        @(negedge clk);
        chk("R3 busy", busy, 1);
        chk("R3 empty", thr_empty, 1);
        shift_frame(b, m[0], v[0]);
        chk("R7 end", tx_end, 1);
        chk("R9 sdo", sdo, 1);
        chk("R9 busy", busy, 0);
      end
    end

    for (int m = 0; m < 2; m++) begin
      logic [7:0] a, b;
      a = 8'hA5 ^ 8'(m * 8'h3C);
      b = 8'h1E ^ 8'(m * 8'h81);
      write_byte(a, m[0]);
      @(negedge clk);
      write_byte(b, m[0]);
      chk("R6 pend", thr_empty, 0);
      shift_frame(a, m[0], 1'b0);
      chk("R6 busy", busy, 1);
      chk("R6 end", tx_end, 0);
      chk("R6 empty", thr_empty, 1);
      shift_frame(b, m[0], 1'b0);
      chk("R7 end2", tx_end, 1);
    end

    write_byte(8'h11, 1'b0);
    @(negedge clk);
    write_byte(8'h22, 1'b0);
    chk("R8 none", overrun, 0);
    write_byte(8'h33, 1'b0);
    chk("R8 set", overrun, 1);
    chk("R8 rd", rd_data, 8'h33);
    @(negedge clk);
    chk("R8 sticky", overrun, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk("R8 clr", overrun, 0);
    shift_frame(8'h11, 1'b0, 1'b0);
    shift_frame(8'h33, 1'b0, 1'b0);
    chk("R8 end", tx_end, 1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule